// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Lock-Aware Fill

This block holds a small fully associative set of address translations. Each slot pairs a 64-bit tag with a 64-bit translation word. Two bits of the translation word have fixed meaning. Bit 63 marks the slot as valid. Bit 6 pins the slot so that a fill can never evict it.

A single request port accepts one of four operations per cycle:

- load the staging tag register;
- fill a slot chosen by the block;
- overwrite a slot chosen by address;
- look up a tag.

A fill and a direct write both take their tag from the staging register and their translation word from the request data. A fill picks its victim by fixed priority: the lowest-numbered invalid slot first, then the lowest-numbered unpinned slot. If every slot is valid and pinned, the fill is dropped and a failure flag is raised.

Every operation answers exactly one cycle later on a registered response port. Page-table walking, demapping and address arithmetic belong to other blocks.

Top module: `fa_tlb`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every slot is invalid, so a lookup of any tag, including zero, misses.
- R2: A request accepted with `req_valid` high produces `rsp_valid` high in the next cycle, and only then.
- R3: Operation code 3 loads `req_data` into the staging tag register and changes no slot. Its response has `rsp_hit`=0, `rsp_tag`=0, `rsp_fail`=0 and `rsp_idx`=0.
- R4: Operation code 0 (fill) writes {staging tag, `req_data`} into the lowest-numbered slot whose bit 63 is clear, and reports that slot on `rsp_idx`.
- R5: When no slot is invalid, a fill writes the lowest-numbered slot whose bit 6 is clear, and reports that slot on `rsp_idx`.
- R6: When every slot has bits 63 and 6 set, a fill writes nothing, and its response has `rsp_fail`=1 for that single response cycle.
- R7: Operation code 1 (direct write) writes {staging tag, `req_data`} into the slot numbered by `req_addr[8:3]`, whether or not that slot is pinned, and reports that slot on `rsp_idx`.
- R8: Operation code 2 (lookup) compares `req_addr` with every tag. It returns `rsp_hit`=1 with the matching tag and the lowest-numbered valid matching slot.
- R9: A lookup that finds no valid match returns `rsp_hit`=0 and `rsp_tag`=0. `rsp_tag` is zero whenever `rsp_hit` is 0.
- R10: A slot whose bit 63 is clear never matches a lookup, even when its tag equals the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 fill, 1 direct write, 2 lookup, 3 load staging tag |
| req_addr | input | 64 | Lookup key, or slot address for a direct write (bits 8:3) |
| req_data | input | 64 | Translation word, or new staging tag value |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Lookup found a valid match |
| rsp_tag | output | 64 | Matching tag on a hit, zero otherwise |
| rsp_idx | output | 6 | Slot written or matched |
| rsp_fail | output | 1 | Fill dropped because every slot is valid and pinned |

## Verification
The checker watches every cycle for these properties:

- the one-cycle request-to-response relation;
- that a hit or a fill failure only follows the matching operation code;
- that a hit returns the key that was asked for;
- that the tag bus reads zero without a hit.

Other behaviours depend on the stored contents and only the bench's scenarios can show them. These are the victim order between invalid and unpinned slots, the preference for the lowest matching slot, the dropped fill leaving the store untouched, and a pinned slot being overwritten by a direct write.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned WORD_W    = 64;
    localparam int unsigned VALID_BIT = 63;
    localparam int unsigned PIN_BIT   = 6;
    localparam int unsigned ADDR_LSB  = 3;

    typedef enum logic [1:0] {
        OP_FILL  = 2'd0,
        OP_WRITE = 2'd1,
        OP_FIND  = 2'd2,
        OP_STAGE = 2'd3
    } tlb_op_e;

    function automatic logic slot_live(input logic [WORD_W-1:0] tte);
        return tte[VALID_BIT];
    endfunction

    function automatic logic slot_pinned(input logic [WORD_W-1:0] tte);
        return tte[PIN_BIT];
    endfunction
endpackage

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int unsigned N  = 64,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int unsigned N  = 64,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [WORD_W-1:0] wtag,
    input  logic [WORD_W-1:0] wtte,
    input  logic [WORD_W-1:0] key,
    output logic [N-1:0]      live,
    output logic [N-1:0]      pinned,
    output logic [N-1:0]      match,
    output logic [WORD_W-1:0] tags [N]
);
    logic [WORD_W-1:0] ttes [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    tags[g] <= '0;
                    ttes[g] <= '0;
                end else if (we && widx == IW'(g)) begin
                    tags[g] <= wtag;
                    ttes[g] <= wtte;
                end
            end
            assign live[g]   = slot_live(ttes[g]);
            assign pinned[g] = slot_pinned(ttes[g]);
            assign match[g]  = live[g] && (tags[g] == key);
        end
    endgenerate
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned N  = 64,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WORD_W-1:0] rsp_tag,
    output logic [IW-1:0]     rsp_idx,
    output logic              rsp_fail
);
    logic [WORD_W-1:0] stage_tag;
    logic [N-1:0]      live, pinned, match;
    logic [WORD_W-1:0] tags [N];
    logic              inv_found, unp_found, hit_found;
    logic [IW-1:0]     inv_idx, unp_idx, hit_idx;
    logic              we, fail_n, hit_n;
    logic [IW-1:0]     widx, idx_n;
    logic [WORD_W-1:0] tag_n;
    tlb_op_e           op;

    assign op = tlb_op_e'(req_op);

    tlb_store #(.N(N), .IW(IW)) u_store (
        .clk(clk), .rst(rst), .we(we), .widx(widx),
        .wtag(stage_tag), .wtte(req_data), .key(req_addr),
        .live(live), .pinned(pinned), .match(match), .tags(tags)
    );

    tlb_pick #(.N(N), .IW(IW)) u_pick_inv (
        .cand(~live), .found(inv_found), .idx(inv_idx));
    tlb_pick #(.N(N), .IW(IW)) u_pick_unp (
        .cand(~pinned), .found(unp_found), .idx(unp_idx));
    tlb_pick #(.N(N), .IW(IW)) u_pick_hit (
        .cand(match), .found(hit_found), .idx(hit_idx));

    always_comb begin
        we     = 1'b0;
        widx   = '0;
        fail_n = 1'b0;
        hit_n  = 1'b0;
        idx_n  = '0;
        tag_n  = '0;
        if (req_valid) begin
            unique case (op)
                OP_FILL: begin
                    if (inv_found) begin
                        we   = 1'b1;
                        widx = inv_idx;
                    end else if (unp_found) begin
                        we   = 1'b1;
                        widx = unp_idx;
                    end else begin
                        fail_n = 1'b1;
                    end
                    idx_n = widx;
                end
                OP_WRITE: begin
                    we    = 1'b1;
                    widx  = req_addr[ADDR_LSB +: IW];
                    idx_n = widx;
                end
                OP_FIND: begin
                    hit_n = hit_found;
                    idx_n = hit_found ? hit_idx : '0;
                    tag_n = hit_found ? tags[hit_idx] : '0;
                end
                OP_STAGE: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_tag <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_tag   <= '0;
            rsp_idx   <= '0;
            rsp_fail  <= 1'b0;
        end else begin
            if (req_valid && op == OP_STAGE) stage_tag <= req_data;
            rsp_valid <= req_valid;
            rsp_hit   <= hit_n;
            rsp_tag   <= tag_n;
            rsp_idx   <= idx_n;
            rsp_fail  <= fail_n;
        end
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
#(
    parameter int unsigned N  = 64,
    parameter int unsigned IW = $clog2(N)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [WORD_W-1:0] req_addr,
    input logic [WORD_W-1:0] req_data,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WORD_W-1:0] rsp_tag,
    input logic [IW-1:0]     rsp_idx,
    input logic              rsp_fail
);
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_hit_from_find_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op != 2'd2) |=> !rsp_hit);

    p_hit_key_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2) |=> (!rsp_hit || rsp_tag == $past(req_addr)));

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> rsp_tag == '0);

    p_fail_from_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op != 2'd0) |=> !rsp_fail);

    p_stage_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3) |=> (rsp_idx == '0 && !rsp_fail));
endmodule

bind fa_tlb tlb_checker #(.N(N), .IW(IW)) u_chk (.*);

// File: tb/sim_fa_tlb.sv
module sim_fa_tlb;
    localparam logic [63:0] V = 64'h8000_0000_0000_0000;
    localparam logic [63:0] L = 64'h40;

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] addr;
        logic [63:0] data;
        logic        hit;
        logic [63:0] tag;
        logic [5:0]  idx;
        logic        fail;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{2'd3, 64'h0,      64'h1000,   1'b0, 64'h0,    6'd0, 1'b0}, // R3
        '{2'd0, 64'h0,      V | 64'h11, 1'b0, 64'h0,    6'd0, 1'b0}, // R4 slot0
        '{2'd3, 64'h0,      64'h2000,   1'b0, 64'h0,    6'd0, 1'b0},
        '{2'd0, 64'h0,      V | L,      1'b0, 64'h0,    6'd1, 1'b0}, // R4 slot1
        '{2'd2, 64'h1000,   64'h0,      1'b1, 64'h1000, 6'd0, 1'b0}, // R8
        '{2'd2, 64'h2000,   64'h0,      1'b1, 64'h2000, 6'd1, 1'b0}, // R8
        '{2'd2, 64'h3000,   64'h0,      1'b0, 64'h0,    6'd0, 1'b0}, // R9
        '{2'd3, 64'h0,      64'h3000,   1'b0, 64'h0,    6'd0, 1'b0},
        '{2'd2, 64'h3000,   64'h0,      1'b0, 64'h0,    6'd0, 1'b0}, // R3 no slot change
        '{2'd1, 64'h5 << 3, V,          1'b0, 64'h0,    6'd5, 1'b0}, // R7
        '{2'd2, 64'h3000,   64'h0,      1'b1, 64'h3000, 6'd5, 1'b0}, // R8
        '{2'd0, 64'h0,      V,          1'b0, 64'h0,    6'd2, 1'b0}, // R4 slot2
        '{2'd2, 64'h3000,   64'h0,      1'b1, 64'h3000, 6'd2, 1'b0}, // R8 lowest match
        '{2'd1, 64'h2 << 3, 64'h0,      1'b0, 64'h0,    6'd2, 1'b0}, // R7 invalidate
        '{2'd2, 64'h3000,   64'h0,      1'b1, 64'h3000, 6'd5, 1'b0}, // R10
        '{2'd3, 64'h0,      64'h4000,   1'b0, 64'h0,    6'd0, 1'b0},
        '{2'd0, 64'h0,      V,          1'b0, 64'h0,    6'd2, 1'b0}  // R4 reuse slot2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [63:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic        rsp_valid, rsp_hit, rsp_fail;
    logic [63:0] rsp_tag;
    logic [5:0]  rsp_idx;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fa_tlb u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_tag(rsp_tag), .rsp_idx(rsp_idx), .rsp_fail(rsp_fail)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [63:0] addr, input logic [63:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        req_data  = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic hit, input logic [63:0] tag,
                              input logic [5:0] idx, input logic fail);
        check({req, " valid"}, 64'(rsp_valid), 64'd1);
        check({req, " hit"},   64'(rsp_hit),   64'(hit));
        check({req, " tag"},   rsp_tag,        tag);
        check({req, " idx"},   64'(rsp_idx),   64'(idx));
        check({req, " fail"},  64'(rsp_fail),  64'(fail));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset valid", 64'(rsp_valid), 64'd0);
        issue(2'd2, 64'h0, 64'h0);
        expect_rsp("R1 empty lookup", 1'b0, 64'h0, 6'd0, 1'b0);
        @(negedge clk);
        check("R2 no request no response", 64'(rsp_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].addr, VEC[i].data);
            expect_rsp($sformatf("R4/R7/R8 vector %0d", i),
                       VEC[i].hit, VEC[i].tag, VEC[i].idx, VEC[i].fail);
        end

        // Fill every slot valid and pinned except slot 9
        issue(2'd3, 64'h0, 64'hA000);
        for (int i = 0; i < 64; i++) begin
            issue(2'd1, 64'(i) << 3, (i == 9) ? V : (V | L));
        end
        issue(2'd3, 64'h0, 64'hB000);
        issue(2'd0, 64'h0, V | L);
        expect_rsp("R5 unpinned victim", 1'b0, 64'h0, 6'd9, 1'b0);
        issue(2'd2, 64'hB000, 64'h0);
        expect_rsp("R5 victim holds tag", 1'b1, 64'hB000, 6'd9, 1'b0);

        // All slots valid and pinned now
        issue(2'd3, 64'h0, 64'h7777);
        issue(2'd0, 64'h0, V);
        expect_rsp("R6 dropped fill", 1'b0, 64'h0, 6'd0, 1'b1);
        issue(2'd2, 64'h7777, 64'h0);
        expect_rsp("R6 store unchanged", 1'b0, 64'h0, 6'd0, 1'b0);

        // Direct write ignores pin
        issue(2'd3, 64'h0, 64'h5555);
        issue(2'd1, 64'h3 << 3, V | L);
        expect_rsp("R7 pinned overwrite", 1'b0, 64'h0, 6'd3, 1'b0);
        issue(2'd2, 64'h5555, 64'h0);
        expect_rsp("R7 overwrite visible", 1'b1, 64'h5555, 6'd3, 1'b0);

        // Invalid slot with matching tag never matches
        issue(2'd1, 64'h3 << 3, L);
        issue(2'd2, 64'h5555, 64'h0);
        expect_rsp("R10 invalid no match", 1'b0, 64'h0, 6'd0, 1'b0);

        // Reset clears store
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset valid again", 64'(rsp_valid), 64'd0);
        issue(2'd2, 64'hA000, 64'h0);
        expect_rsp("R1 store cleared", 1'b0, 64'h0, 6'd0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual hung expected done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule